// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core. It handles one non-maskable line and four maskable lines: a second timer, a vertical-sync input, a first timer and a power-monitor pin. When the core may take an interrupt, the block raises a one-cycle request strobe and presents the 12-bit program address of the handler's vector. It also shows whether any handler is running. The core answers each completed handler with a one-cycle return pulse.

Software sets the block up through a write-only option byte on the data bus. That byte holds the global enable for the maskable lines, a level or edge choice for the second-timer line, and the edge polarity for vertical sync. The maskable lines are arbitrated in a fixed order and never nest. The non-maskable line can break into a maskable handler. A two-entry service stack brings the preempted handler back when the non-maskable handler returns.

Top module: `prio_vec_intc`

## Requirements
- R1: After a synchronous reset, `irq` is 0, `in_service` is 0 and `vec_addr` is 0. All three option bits are cleared, so the second-timer line is edge-triggered, vertical sync fires on its falling edge and maskable dispatch is blocked.
- R2: The option byte is loaded only by a write with `wr_en` high and `wr_addr` equal to 0xC8, and the whole byte is taken at once. Bit 6 selects level mode for the second timer, bit 5 selects a rising edge for vertical sync and bit 4 is the global enable. Bits 7 and 3..0 have no effect, and writes to any other address are ignored.
- R3: While the global enable is 0, no maskable handler is dispatched and latched maskable requests stay pending. They are dispatched once the enable is set, provided no handler is in service.
- R4: Pending maskable requests are served in the order second timer (vector 0xFF6), vertical sync (0xFF4), first timer (0xFF2), power pin (0xFF0).
- R5: A falling edge on `nmi_n` is latched and dispatched with vector 0xFFC, even while the global enable is 0.
- R6: Each dispatch asserts `irq` for one cycle, with the matching vector on `vec_addr` in that same cycle, and sets `in_service`. `vec_addr` holds its value until the next dispatch.
- R7: In level mode, the second-timer line requests service on every cycle it is low and is not latched. A low level that ends before it is serviced leaves no request, and a level still low after the return dispatches again.
- R8: In edge mode, the second timer, first timer and power pin latch a request on a falling edge.
- R9: With bit 5 clear, vertical sync latches on a falling edge. With bit 5 set, it latches on a rising edge, and a falling edge is then ignored.
- R10: While any handler is in service, no maskable handler is dispatched.
- R11: A non-maskable request preempts a running maskable handler. After the non-maskable return, `in_service` stays high for the resumed maskable handler.
- R12: A non-maskable request that arrives during a non-maskable handler waits, and it is dispatched after that handler returns.
- R13: Dispatch clears the latched request of the vector taken, so one edge is served exactly once. Other pending requests are kept.
- R14: Each `reti` pulse pops one service level. A `reti` with nothing in service has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Data bus write strobe |
| wr_addr | input | 8 | Data bus write address |
| wr_data | input | 8 | Data bus write byte |
| nmi_n | input | 1 | Non-maskable request line, falling edge |
| tmr2_n | input | 1 | Second timer request, active low (vector #1) |
| vsync | input | 1 | Vertical sync request, edge selectable (vector #2) |
| tmr1_n | input | 1 | First timer request, active low (vector #3) |
| pwr_n | input | 1 | Power-monitor pin request, active low (vector #4) |
| reti | input | 1 | Return-from-interrupt pulse from the core |
| irq | output | 1 | One-cycle dispatch strobe to the core |
| vec_addr | output | 12 | Program address of the dispatched vector |
| in_service | output | 1 | High while any handler is in service |

## Verification
The assertions check the following on every clock:
- A maskable dispatch never happens while a handler is running or while the global enable is low.
- The service stack never holds two maskable levels, and it never pushes a non-maskable entry onto another one.
- A latched flag drops after it is acknowledged.
- `vec_addr` only moves with a strobe.

Only the bench scenarios can show the rest:
- The priority order across four pending sources.
- The edge polarity choice for vertical sync.
- The non-latching level mode.
- Requests surviving a disabled interval.
- The correct resumption of a preempted handler.

The bench runs these scenarios against its own cycle model.

// File: rtl/intc_pkg.sv
// Shared types for the vectored interrupt controller.
// Assumes: two service levels at most (one maskable plus one non-maskable).
package intc_pkg;

    // Kind of handler held in one service-stack entry
    typedef enum logic [1:0] {
        SVC_NONE = 2'd0,
        SVC_MASK = 2'd1,
        SVC_NMI  = 2'd2
    } svc_kind_e;

endpackage

// File: rtl/intc_src_latch.sv
// Edge detector and pending flag for one request line.
// Detects a falling edge, or a rising edge when rise_sel is high.
// Edges are ignored until one clock after reset.
// When lat_en is low the flag is held clear (the line is then used as a level).
// Assumes: din is synchronous to clk.
module intc_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic rise_sel,
    input  logic lat_en,
    input  logic clr,
    output logic evt,
    output logic pend
);

    logic prev_q;
    logic armed_q;

    // Track the previous line level and arm detection after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= din;
            armed_q <= 1'b1;
        end
    end

    assign evt = armed_q && (rise_sel ? (!prev_q && din) : (prev_q && !din));

    // Pending flag: set by an edge, cleared on acknowledge, held low when latching is off
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (!lat_en)
            pend <= 1'b0;
        else
            pend <= (pend && !clr) || evt;
    end

    // R13
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !evt |=> !pend);

    // R8
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat_en && evt |=> pend);

endmodule

// File: rtl/intc_prio_arb.sv
// Fixed-priority arbiter: the lowest index with a request wins.
// Index 0 maps to maskable vector #1.
// Assumes: purely combinational; the caller qualifies valid with enable state.
module intc_prio_arb #(
    parameter  int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);

    // Scan from lowest to highest priority so the highest one is written last
    always_comb begin
        valid = |req;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) idx = IW'(k);
        end
    end

endmodule

// File: rtl/intc_svc_stack.sv
// Two-entry service stack.
// Level 0 holds the first handler; level 1 holds only a non-maskable handler
// that preempted a maskable one.
// pop takes precedence over any push in the same cycle.
// Assumes: the caller issues a push only when the nesting rules allow it.
module intc_svc_stack
    import intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_mask,
    input  logic       push_nmi,
    input  logic       pop,
    output logic [1:0] depth,
    output logic       top_nmi
);

    svc_kind_e lvl0_q;
    svc_kind_e lvl1_q;

    // Push and pop service levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl0_q <= SVC_NONE;
            lvl1_q <= SVC_NONE;
        end else if (pop) begin
            if (lvl1_q != SVC_NONE) lvl1_q <= SVC_NONE;
            else                    lvl0_q <= SVC_NONE;
        end else if (push_nmi) begin
            if (lvl0_q == SVC_NONE) lvl0_q <= SVC_NMI;
            else                    lvl1_q <= SVC_NMI;
        end else if (push_mask) begin
            lvl0_q <= SVC_MASK;
        end
    end

    // Depth and kind of the newest entry
    always_comb begin
        depth   = 2'((lvl0_q != SVC_NONE) ? 1 : 0) + 2'((lvl1_q != SVC_NONE) ? 1 : 0);
        top_nmi = (lvl1_q == SVC_NMI) || (lvl1_q == SVC_NONE && lvl0_q == SVC_NMI);
    end

    // R10
    no_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl1_q != SVC_MASK);

    // R10
    mask_push_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_mask && !pop |-> depth == 2'd0);

    // R12
    nmi_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_nmi |-> !top_nmi);

    // R14
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop && depth == 2'd0 |=> depth == 2'd0);

endmodule

// File: rtl/prio_vec_intc.sv
// Vectored interrupt controller top.
// Holds the write-only option byte and latches the five request lines.
// Arbitrates the maskable ones in fixed order and applies the nesting rules.
// Registers the dispatch strobe together with the vector address.
// Assumes: all request lines and the bus are synchronous to clk;
// reti is a one-cycle pulse.
module prio_vec_intc #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] OPT_ADDR = 'hC8,
    parameter int                VEC_W    = 12,
    parameter logic [VEC_W-1:0]  NMI_VEC  = 'hFFC,
    parameter logic [VEC_W-1:0]  MASK_TOP = 'hFF8,
    parameter int                EL1_BIT  = 6,
    parameter int                ES2_BIT  = 5,
    parameter int                GEN_BIT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              nmi_n,
    input  logic              tmr2_n,
    input  logic              vsync,
    input  logic              tmr1_n,
    input  logic              pwr_n,
    input  logic              reti,
    output logic              irq,
    output logic [VEC_W-1:0]  vec_addr,
    output logic              in_service
);

    localparam int N_MASK = 4;
    localparam int N_SRC  = N_MASK + 1;
    localparam int IW     = $clog2(N_MASK);
    localparam int NMI_I  = 0;
    localparam int LVL_I  = 1;
    localparam int VS_I   = 2;

    logic             el1_q, es2_q, gen_q;
    logic [N_SRC-1:0] src_line;
    logic [N_SRC-1:0] src_evt;
    logic [N_SRC-1:0] src_pend;
    logic [N_SRC-1:0] src_clr;
    logic [N_MASK-1:0] mask_req;
    logic             arb_valid;
    logic [IW-1:0]    arb_idx;
    logic [1:0]       depth;
    logic             top_nmi;
    logic             take_nmi, take_mask;
    logic             wr_unused;

    assign wr_unused = ^{wr_data[DATA_W-1:EL1_BIT+1], wr_data[GEN_BIT-1:0]};

    // Option byte: full-byte write at its address, no read path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            el1_q <= 1'b0;
            es2_q <= 1'b0;
            gen_q <= 1'b0;
        end else if (wr_en && wr_addr == OPT_ADDR) begin
            el1_q <= wr_data[EL1_BIT];
            es2_q <= wr_data[ES2_BIT];
            gen_q <= wr_data[GEN_BIT];
        end
    end

    assign src_line = {pwr_n, tmr1_n, vsync, tmr2_n, nmi_n};

    // One edge detector and pending flag per request line
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic rise_sel_w, lat_en_w;
        if (i == VS_I) begin : g_vs
            assign rise_sel_w = es2_q;
        end else begin : g_fall
            assign rise_sel_w = 1'b0;
        end
        if (i == LVL_I) begin : g_lvl
            assign lat_en_w = !el1_q;
        end else begin : g_edge
            assign lat_en_w = 1'b1;
        end
        intc_src_latch u_latch (
            .clk      (clk),
            .rst_n    (rst_n),
            .din      (src_line[i]),
            .rise_sel (rise_sel_w),
            .lat_en   (lat_en_w),
            .clr      (src_clr[i]),
            .evt      (src_evt[i]),
            .pend     (src_pend[i])
        );
    end

    // Maskable request vector; the second-timer line is a direct level in level mode
    always_comb begin
        mask_req        = src_pend[N_SRC-1:1];
        mask_req[0]     = el1_q ? !tmr2_n : src_pend[LVL_I];
    end

    intc_prio_arb #(.N(N_MASK)) u_arb (
        .req   (mask_req),
        .valid (arb_valid),
        .idx   (arb_idx)
    );

    // Nesting rules: NMI unless an NMI is running; maskable only when idle and enabled
    always_comb begin
        take_nmi  = !reti && src_pend[NMI_I] && !top_nmi && depth != 2'd2;
        take_mask = !reti && depth == 2'd0 && gen_q && !src_pend[NMI_I] && arb_valid;
        src_clr        = '0;
        src_clr[NMI_I] = take_nmi;
        for (int k = 0; k < N_MASK; k++) begin
            if (take_mask && arb_idx == IW'(k)) src_clr[k+1] = 1'b1;
        end
    end

    intc_svc_stack u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_mask (take_mask),
        .push_nmi  (take_nmi),
        .pop       (reti),
        .depth     (depth),
        .top_nmi   (top_nmi)
    );

    // Dispatch strobe and vector register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            vec_addr <= '0;
        end else begin
            irq <= take_nmi || take_mask;
            if (take_nmi)
                vec_addr <= NMI_VEC;
            else if (take_mask)
                vec_addr <= MASK_TOP - VEC_W'(2 * (32'(arb_idx) + 1));
        end
    end

    assign in_service = depth != 2'd0;

    // R6
    irq_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> in_service);

    // R6
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> $stable(vec_addr));

    // R3
    gen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && vec_addr != NMI_VEC |-> $past(gen_q));

    // R10
    mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && vec_addr != NMI_VEC |-> !$past(in_service));

endmodule

// File: tb/prio_vec_intc_tb.sv
// Bench: behavioural cycle model compared every clock, plus directed scenarios.
module prio_vec_intc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [7:0]  wr_data = 8'h00;
    logic [4:0]  lines = 5'b11111;   // [0] nmi, [1] tmr2, [2] vsync, [3] tmr1, [4] pwr
    logic        reti = 1'b0;
    logic        irq;
    logic [11:0] vec_addr;
    logic        in_service;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    prio_vec_intc u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .nmi_n      (lines[0]),
        .tmr2_n     (lines[1]),
        .vsync      (lines[2]),
        .tmr1_n     (lines[3]),
        .pwr_n      (lines[4]),
        .reti       (reti),
        .irq        (irq),
        .vec_addr   (vec_addr),
        .in_service (in_service)
    );

    // ---------------- reference model ----------------
    bit   [4:0]  m_prev;
    bit          m_armed, m_el1, m_es2, m_gen, m_irq, m_started;
    bit   [4:0]  m_pend;
    logic [11:0] m_vec;
    int          m_stk[$];   // 1 = maskable, 2 = non-maskable
    bit   [4:0]  ev;
    bit   [3:0]  rq;
    int          sel;
    bit          tk_n, tk_m, topn;

    always @(posedge clk) begin
        m_started <= 1'b1;
        if (!rst_n) begin
            m_prev = '0; m_armed = 0; m_el1 = 0; m_es2 = 0; m_gen = 0;
            m_irq = 0; m_pend = '0; m_vec = '0; m_stk.delete();
        end else begin
            for (int i = 0; i < 5; i++) begin
                if (i == 2 && m_es2) ev[i] = m_armed && !m_prev[i] && lines[i];
                else                 ev[i] = m_armed && m_prev[i] && !lines[i];
            end
            rq[0] = m_el1 ? !lines[1] : m_pend[1];
            for (int k = 1; k < 4; k++) rq[k] = m_pend[k+1];
            sel = -1;
            for (int k = 3; k >= 0; k--) if (rq[k]) sel = k;
            topn = (m_stk.size() > 0) && (m_stk[m_stk.size()-1] == 2);
            tk_n = !reti && m_pend[0] && !topn && m_stk.size() < 2;
            tk_m = !reti && m_stk.size() == 0 && m_gen && !m_pend[0] && sel >= 0;
            if (tk_n) m_pend[0] = 0;
            if (tk_m) m_pend[sel+1] = 0;
            m_pend = m_pend | ev;
            if (m_el1) m_pend[1] = 0;
            if (reti) begin
                if (m_stk.size() > 0) void'(m_stk.pop_back());
            end else if (tk_n) m_stk.push_back(2);
            else if (tk_m) m_stk.push_back(1);
            m_irq = tk_n || tk_m;
            if (tk_n) m_vec = 12'hFFC;
            else if (tk_m) m_vec = 12'hFF8 - 12'(2 * (sel + 1));
            if (wr_en && wr_addr == 8'hC8) begin
                m_el1 = wr_data[6]; m_es2 = wr_data[5]; m_gen = wr_data[4];
            end
            m_prev  = lines;
            m_armed = 1;
        end
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of all outputs with the model (R6, R10, R13, R14)
    always @(negedge clk) begin
        if (m_started && !done) begin
            check(irq == m_irq, "R6 irq vs model", 32'(irq), 32'(m_irq));
            check(vec_addr == m_vec, "R6 vec_addr vs model", 32'(vec_addr), 32'(m_vec));
            check(in_service == (m_stk.size() != 0), "R14 in_service vs model",
                  32'(in_service), 32'(m_stk.size() != 0));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic opt_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse(int i);
        @(negedge clk); lines[i] = ~lines[i];
        @(negedge clk); lines[i] = ~lines[i];
    endtask

    task automatic do_reti();
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0;
    endtask

    task automatic expect_irq(string tag, logic [11:0] v, int maxc);
        bit got = 0;
        for (int k = 0; k < maxc && !got; k++) begin
            @(negedge clk);
            if (irq) got = 1;
        end
        check(got && vec_addr == v, tag, got ? 32'(vec_addr) : 32'hDEAD, 32'(v));
    endtask

    task automatic expect_quiet(string tag, int n);
        bit seen = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (irq) seen = 1;
        end
        check(!seen, tag, 32'(seen), 0);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(irq == 1'b0, "R1 irq in reset", 32'(irq), 0);
        check(in_service == 1'b0, "R1 in_service in reset", 32'(in_service), 0);
        check(vec_addr == 12'h000, "R1 vec_addr in reset", 32'(vec_addr), 0);
        rst_n = 1'b1;
        // R1: enable off after reset, so an edge only pends
        pulse(3);
        expect_quiet("R1 gen clear after reset", 6);
        opt_write(8'hC8, 8'h10);
        expect_irq("R8 tmr1 falling edge", 12'hFF2, 6);
        do_reti();
        check(in_service == 1'b0, "R14 reti clears service", 32'(in_service), 0);

        // R3 / R4: four pending requests while disabled, then served in order
        opt_write(8'hC8, 8'h00);
        pulse(4); pulse(3); pulse(2); pulse(1);
        expect_quiet("R3 disabled holds pending", 8);
        opt_write(8'hC8, 8'h10);
        expect_irq("R4 first tmr2", 12'hFF6, 6);
        do_reti();
        expect_irq("R4 second vsync", 12'hFF4, 6);
        do_reti();
        expect_irq("R4 third tmr1", 12'hFF2, 6);
        do_reti();
        expect_irq("R4 fourth pwr", 12'hFF0, 6);
        do_reti();
        expect_quiet("R13 each edge served once", 6);

        // R2: wrong address ignored, unused bits ignored
        opt_write(8'hC9, 8'h00);
        pulse(4);
        expect_irq("R2 other address ignored", 12'hFF0, 6);
        do_reti();
        opt_write(8'hC8, 8'h8F);
        pulse(3);
        expect_quiet("R2 unused bits do not enable", 6);
        opt_write(8'hC8, 8'h10);
        expect_irq("R2 bit4 enables", 12'hFF2, 6);
        do_reti();

        // R7: level mode is not latched
        opt_write(8'hC8, 8'h40);
        @(negedge clk); lines[1] = 1'b0;
        repeat (3) @(negedge clk);
        lines[1] = 1'b1;
        opt_write(8'hC8, 8'h50);
        expect_quiet("R7 short level not latched", 6);
        @(negedge clk); lines[1] = 1'b0;
        expect_irq("R7 low level dispatch", 12'hFF6, 6);
        do_reti();
        expect_irq("R7 level still low redispatch", 12'hFF6, 6);
        @(negedge clk); lines[1] = 1'b1;
        do_reti();
        expect_quiet("R7 released level quiet", 6);

        // R9: vertical sync edge selection
        opt_write(8'hC8, 8'h30);
        @(negedge clk); lines[2] = 1'b0;
        expect_quiet("R9 falling ignored in rise mode", 6);
        @(negedge clk); lines[2] = 1'b1;
        expect_irq("R9 rising edge", 12'hFF4, 6);
        do_reti();
        opt_write(8'hC8, 8'h10);

        // R10 / R11 / R13: preemption and resume
        pulse(3);
        expect_irq("R10 tmr1 enters service", 12'hFF2, 6);
        pulse(4);
        expect_quiet("R10 no maskable nesting", 6);
        pulse(0);
        expect_irq("R11 nmi preempts", 12'hFFC, 6);
        do_reti();
        check(in_service == 1'b1, "R11 maskable resumed", 32'(in_service), 1);
        expect_quiet("R10 resumed handler not nested", 6);
        do_reti();
        expect_irq("R13 pending pwr after return", 12'hFF0, 6);
        do_reti();

        // R12: nmi during nmi waits
        pulse(0);
        expect_irq("R12 first nmi", 12'hFFC, 6);
        pulse(0);
        expect_quiet("R12 second nmi waits", 6);
        do_reti();
        expect_irq("R12 second nmi after return", 12'hFFC, 6);
        do_reti();

        // R5: nmi works with global enable clear
        opt_write(8'hC8, 8'h00);
        pulse(0);
        expect_irq("R5 nmi with enable off", 12'hFFC, 6);
        do_reti();

        // R14: stray return has no effect
        do_reti();
        check(in_service == 1'b0, "R14 stray reti", 32'(in_service), 0);
        opt_write(8'hC8, 8'h10);
        pulse(4);
        expect_irq("R14 normal after stray reti", 12'hFF0, 6);
        do_reti();
        expect_quiet("R14 idle at end", 4);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule